// File: doc/BRIEF.md
# 64-bit Compare Timer

This block is a global timer built around a 64-bit up-counter and one 64-bit compare channel. Software preloads the counter as two 32-bit words, starts it with a control bit, and reads it back one word at a time. To get a consistent 64-bit value, software reads the high word, then the low word, then the high word again, and retries if the two high reads differ.

The compare channel signals a match when the running count equals the programmed compare value. A match sets a sticky status bit, and software clears that bit by writing a one to it. The interrupt line is the status bit gated by an enable bit. In single-shot operation the channel disarms after one match, and it stays disarmed until software writes a new compare value. With auto-increment on, every match adds a programmed 32-bit step to the compare value, so the channel produces periodic interrupts without software reloading it.

Access is through a plain 32-bit register port with separate write and read strobes. Read data is registered.

Top module: `gtc_top`

## Requirements
- R1: While control bit 8 (offset 0x240) is 1, the 64-bit counter adds one on every clock edge, and the low word carries into the high word (0x100 is the low word, 0x104 the high word).
- R2: While control bit 8 is 0, the counter keeps its value.
- R3: A write to 0x100 or 0x104 loads only that word of the counter. On that edge the load replaces counting, and the other word is left unchanged.
- R4: A read strobe returns the addressed register on reg_rdata one clock edge later. The readable registers are the counter words (0x100/0x104), the compare words (0x200 low, 0x204 high), the step (0x208), control (0x240: bit 0 compare enable, bit 1 auto-increment, bit 8 run), status (0x244 bit 0) and enable (0x248 bit 0). An unmapped address reads 0.
- R5: A match occurs when control bit 0 is 1, the channel is armed, and the counter equals the compare value. The status bit sets on the clock edge after the cycle in which they are equal. With control bit 0 clear, no match occurs.
- R6: With auto-increment off, a match disarms the channel. A write to 0x200 or 0x204 re-arms it.
- R7: With auto-increment on, each match adds the 32-bit step at 0x208 to the compare value, and the channel stays armed.
- R8: Writing 1 to bit 0 of 0x244 clears the status bit, and writing 0 has no effect. A match on the same edge as the clear wins.
- R9: irq_o is registered and equals the status bit AND enable bit 0 of 0x248, updated on the same edge as those bits.
- R10: After reset the counter, compare value, step, control, status, enable, read data and irq_o are all 0, and the channel is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The step and disarm properties assume that a match is not checked on an edge where the compare value is being rewritten, and the counting properties exclude edges that carry a counter load. The stimulus stops the counter before it reloads it and writes the compare words only while no match is due. Running-counter reads follow the high-low-high pattern across a carry, so the expected values follow from the number of edges since the run bit was written.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int unsigned OFS_CNT_LO = 'h100;
  localparam int unsigned OFS_CNT_HI = 'h104;
  localparam int unsigned OFS_CMP_LO = 'h200;
  localparam int unsigned OFS_CMP_HI = 'h204;
  localparam int unsigned OFS_STEP   = 'h208;
  localparam int unsigned OFS_CTRL   = 'h240;
  localparam int unsigned OFS_STS    = 'h244;
  localparam int unsigned OFS_ENA    = 'h248;

  localparam int unsigned CTRL_CMPEN_BIT = 0;
  localparam int unsigned CTRL_AUTO_BIT  = 1;
  localparam int unsigned CTRL_RUN_BIT   = 8;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic cmp_lo;
    logic cmp_hi;
    logic step;
    logic ctrl;
    logic sts;
    logic ena;
  } wr_sel_t;
endpackage

// File: rtl/gtc_regdec.sv
module gtc_regdec
  import gtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output wr_sel_t           sel
);
  always_comb begin
    sel        = '0;
    sel.cnt_lo = wr && (addr == ADDR_W'(OFS_CNT_LO));
    sel.cnt_hi = wr && (addr == ADDR_W'(OFS_CNT_HI));
    sel.cmp_lo = wr && (addr == ADDR_W'(OFS_CMP_LO));
    sel.cmp_hi = wr && (addr == ADDR_W'(OFS_CMP_HI));
    sel.step   = wr && (addr == ADDR_W'(OFS_STEP));
    sel.ctrl   = wr && (addr == ADDR_W'(OFS_CTRL));
    sel.sts    = wr && (addr == ADDR_W'(OFS_STS));
    sel.ena    = wr && (addr == ADDR_W'(OFS_ENA));
  end
endmodule

// File: rtl/gtc_counter.sv
module gtc_counter #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 2,
  localparam int unsigned CNT_W    = WORD_W * NUM_WORDS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [NUM_WORDS-1:0] ld,
  input  logic [WORD_W-1:0]    wdata,
  output logic [CNT_W-1:0]     cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (|ld) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (ld[w]) cnt_q[w*WORD_W +: WORD_W] <= wdata;
      end
    end else if (run) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !(|ld)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("count step"); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !(|ld)) |=> $stable(cnt_q)) else $error("count hold"); // R2
  AST_CNT_LOAD_LO: assert property (@(posedge clk) disable iff (rst)
    ld[0] |=> (cnt_q[WORD_W-1:0] == $past(wdata))) else $error("count load"); // R3
endmodule

// File: rtl/gtc_compare.sv
module gtc_compare #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 2,
  localparam int unsigned CNT_W    = WORD_W * NUM_WORDS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 autoinc,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [NUM_WORDS-1:0] ld,
  input  logic                 ld_step,
  input  logic [WORD_W-1:0]    wdata,
  output logic [CNT_W-1:0]     cmp,
  output logic [WORD_W-1:0]    step,
  output logic                 match
);
  logic [CNT_W-1:0]  cmp_q;
  logic [WORD_W-1:0] step_q;
  logic              armed_q;

  assign match = en && armed_q && (cnt == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= '0;
      step_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (|ld) begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (ld[w]) cmp_q[w*WORD_W +: WORD_W] <= wdata;
        end
      end else if (match && autoinc) begin
        cmp_q <= cmp_q + CNT_W'(step_q);
      end
      if (ld_step) step_q <= wdata;
      if (|ld) armed_q <= 1'b1;
      else if (match && !autoinc) armed_q <= 1'b0;
    end
  end

  assign cmp  = cmp_q;
  assign step = step_q;

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
    (match && !autoinc && !(|ld)) |=> !armed_q) else $error("disarm"); // R6
  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    (|ld) |=> armed_q) else $error("rearm"); // R6
  AST_AUTOINC_ADD: assert property (@(posedge clk) disable iff (rst)
    (match && autoinc && !(|ld)) |=> (cmp_q == $past(cmp_q) + CNT_W'($past(step_q))))
    else $error("auto step"); // R7
endmodule

// File: rtl/gtc_irqctl.sv
module gtc_irqctl (
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic wr_sts,
  input  logic wr_ena,
  input  logic wbit,
  output logic sts,
  output logic ena,
  output logic irq
);
  logic sts_q, ena_q, irq_q;
  logic sts_d, ena_d;

  always_comb begin
    sts_d = match || (sts_q && !(wr_sts && wbit));
    ena_d = wr_ena ? wbit : ena_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      ena_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      ena_q <= ena_d;
      irq_q <= sts_d && ena_d;
    end
  end

  assign sts = sts_q;
  assign ena = ena_q;
  assign irq = irq_q;

  AST_STS_SET: assert property (@(posedge clk) disable iff (rst)
    match |=> sts_q) else $error("status set"); // R5
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_sts && wbit && !match) |=> !sts_q) else $error("w1c"); // R8
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    !ena_q |-> !irq_q) else $error("irq mask"); // R9
endmodule

// File: rtl/gtc_top.sv
module gtc_top
  import gtc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned NUM_WORDS = 2,
  localparam int unsigned CNT_W     = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_o
);
  wr_sel_t          sel;
  logic             run_q, cmpen_q, auto_q;
  logic [CNT_W-1:0] cnt, cmp;
  logic [WORD_W-1:0] step;
  logic             match, sts, ena;
  logic [WORD_W-1:0] rdata_q;

  gtc_regdec #(.ADDR_W(ADDR_W)) dec_i (
    .wr(reg_wr), .addr(reg_addr), .sel(sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cmpen_q <= 1'b0;
      auto_q  <= 1'b0;
    end else if (sel.ctrl) begin
      run_q   <= reg_wdata[CTRL_RUN_BIT];
      cmpen_q <= reg_wdata[CTRL_CMPEN_BIT];
      auto_q  <= reg_wdata[CTRL_AUTO_BIT];
    end
  end

  gtc_counter #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) cnt_i (
    .clk(clk), .rst(rst), .run(run_q),
    .ld({sel.cnt_hi, sel.cnt_lo}), .wdata(reg_wdata), .cnt(cnt)
  );

  gtc_compare #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) cmp_i (
    .clk(clk), .rst(rst), .en(cmpen_q), .autoinc(auto_q), .cnt(cnt),
    .ld({sel.cmp_hi, sel.cmp_lo}), .ld_step(sel.step), .wdata(reg_wdata),
    .cmp(cmp), .step(step), .match(match)
  );

  gtc_irqctl irq_i (
    .clk(clk), .rst(rst), .match(match), .wr_sts(sel.sts), .wr_ena(sel.ena),
    .wbit(reg_wdata[0]), .sts(sts), .ena(ena), .irq(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_W'(OFS_CNT_LO): rdata_q <= cnt[WORD_W-1:0];
        ADDR_W'(OFS_CNT_HI): rdata_q <= cnt[CNT_W-1:WORD_W];
        ADDR_W'(OFS_CMP_LO): rdata_q <= cmp[WORD_W-1:0];
        ADDR_W'(OFS_CMP_HI): rdata_q <= cmp[CNT_W-1:WORD_W];
        ADDR_W'(OFS_STEP):   rdata_q <= step;
        ADDR_W'(OFS_CTRL): begin
          rdata_q                 <= '0;
          rdata_q[CTRL_RUN_BIT]   <= run_q;
          rdata_q[CTRL_AUTO_BIT]  <= auto_q;
          rdata_q[CTRL_CMPEN_BIT] <= cmpen_q;
        end
        ADDR_W'(OFS_STS):    rdata_q <= WORD_W'(sts);
        ADDR_W'(OFS_ENA):    rdata_q <= WORD_W'(ena);
        default:             rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(rdata_q)) else $error("rdata hold"); // R4
endmodule

// File: tb/gtc_top_tb_top.sv
`timescale 1ns/1ps
module gtc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #2.5 clk = ~clk;

  gtc_top dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always @(posedge clk) rd_d <= reg_rd;

  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual 0x%08h expected 0x%08h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq_o actual %0b expected %0b", t, irq_o, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    #1;
    // R10 reset values
    chk_irq(1'b0, "R10 irq after reset");
    rd(12'h240, 32'h0, "R10 ctrl reset");
    rd(12'h100, 32'h0, "R10 count reset");
    rd(12'h244, 32'h0, "R10 status reset");
    rd(12'h200, 32'h0, "R10 compare reset");
    // R4 register readback
    wr(12'h208, 32'h0000_0055);
    rd(12'h208, 32'h0000_0055, "R4 step readback");
    wr(12'h200, 32'h0000_1234);
    rd(12'h200, 32'h0000_1234, "R4 compare readback");
    rd(12'h0FC, 32'h0, "R4 unmapped read");
    wr(12'h240, 32'h0000_0003);
    rd(12'h240, 32'h0000_0003, "R4 ctrl readback");
    wr(12'h240, 32'h0);
    // R3 word loads
    wr(12'h100, 32'hFFFF_FFFE);
    wr(12'h104, 32'h0);
    rd(12'h100, 32'hFFFF_FFFE, "R3 low load");
    wr(12'h104, 32'h0000_00AB);
    rd(12'h104, 32'h0000_00AB, "R3 high load");
    rd(12'h100, 32'hFFFF_FFFE, "R3 low untouched");
    wr(12'h104, 32'h0);
    // R1 carry while running, high-low-high read
    wr(12'h240, 32'h0000_0100);
    rd(12'h104, 32'h0, "R1 high before carry");
    rd(12'h100, 32'hFFFF_FFFF, "R1 low running");
    rd(12'h104, 32'h1, "R1 high after carry");
    wr(12'h240, 32'h0);
    idle(3);
    // R2 hold while stopped
    rd(12'h100, 32'h2, "R2 low held");
    rd(12'h104, 32'h1, "R2 high held");
    // R5 comparator disabled: no match
    wr(12'h100, 32'h0);
    wr(12'h104, 32'h0);
    wr(12'h200, 32'd10);
    wr(12'h204, 32'h0);
    wr(12'h248, 32'h1);
    wr(12'h240, 32'h0000_0100);
    idle(14);
    wr(12'h240, 32'h0);
    chk_irq(1'b0, "R5 disabled no irq");
    rd(12'h244, 32'h0, "R5 disabled no status");
    // R5/R9 match timing
    wr(12'h100, 32'h0);
    wr(12'h240, 32'h0000_0101);
    idle(10);
    chk_irq(1'b0, "R5 no status in equal cycle");
    idle(1);
    chk_irq(1'b1, "R5 status edge after equal");
    wr(12'h240, 32'h0);
    // R8 write-one-to-clear
    wr(12'h244, 32'h0);
    rd(12'h244, 32'h1, "R8 write 0 no effect");
    chk_irq(1'b1, "R8 irq kept");
    wr(12'h244, 32'h1);
    rd(12'h244, 32'h0, "R8 write 1 clears");
    chk_irq(1'b0, "R8 irq cleared");
    // R6 one-shot: disarmed after match
    wr(12'h100, 32'd5);
    wr(12'h240, 32'h0000_0101);
    idle(10);
    wr(12'h240, 32'h0);
    chk_irq(1'b0, "R6 no second match");
    rd(12'h244, 32'h0, "R6 status stays clear");
    // R6 rearm by compare write
    wr(12'h204, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h240, 32'h0000_0101);
    idle(11);
    chk_irq(1'b1, "R6 rearmed match");
    wr(12'h240, 32'h0);
    wr(12'h244, 32'h1);
    // R9 enable gating
    wr(12'h248, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h200, 32'd3);
    wr(12'h240, 32'h0000_0101);
    idle(6);
    wr(12'h240, 32'h0);
    chk_irq(1'b0, "R9 masked irq");
    rd(12'h244, 32'h1, "R9 status while masked");
    wr(12'h248, 32'h1);
    chk_irq(1'b1, "R9 unmask raises irq");
    wr(12'h244, 32'h1);
    chk_irq(1'b0, "R9 clear drops irq");
    // R7 auto-increment
    wr(12'h100, 32'h0);
    wr(12'h104, 32'h0);
    wr(12'h208, 32'd4);
    wr(12'h200, 32'd3);
    wr(12'h204, 32'h0);
    wr(12'h240, 32'h0000_0103);
    idle(12);
    wr(12'h240, 32'h0000_0002);
    rd(12'h200, 32'd15, "R7 compare advanced three steps");
    rd(12'h204, 32'h0, "R7 compare high");
    rd(12'h100, 32'd13, "R7 count at stop");
    rd(12'h244, 32'h1, "R7 status set");
    wr(12'h244, 32'h1);
    wr(12'h240, 32'h0000_0103);
    idle(2);
    chk_irq(1'b0, "R7 before next periodic match");
    idle(1);
    chk_irq(1'b1, "R7 periodic match without reload");
    wr(12'h240, 32'h0);
    rd(12'h200, 32'd19, "R7 compare after fourth match");
    idle(3);
    finish_run();
  end
endmodule